// File: doc/BRIEF.md
# Operate Unit with Condition Flags

This block executes the three arithmetic and logic instructions of a small 16-bit register machine: addition, bitwise AND and bitwise complement. It takes one instruction word plus the two register values that the surrounding pipeline has already fetched. In the same cycle it produces the result, the destination register index, a write enable and the source indices that the register file needs. A three-bit condition register remembers the sign class of the last result that was written: negative, zero or positive.

The input and output form one pass-through stream. An instruction counts as transferred in any cycle where `in_valid` and `out_ready` are both high. `in_ready` simply follows `out_ready`, and `out_valid` simply follows `in_valid`. When the consumer stalls, the producer must hold the instruction and both operands stable. The condition register changes only on a transfer of a well-formed operate instruction. Register storage and memory sit outside the block.

Top module: `opu_core`

## Requirements
- R1: Opcode 0001 in bits 15:12 with bit 5 clear gives `result` = `src_a` + `src_b`, taken modulo 2^16. `dst_idx` is instruction bits 11:9 and `wr_en` is high while `in_valid` is high.
- R2: Opcode 0001 with bit 5 set adds bits 4:0 to `src_a`, with those bits treated as a two's-complement value sign-extended to 16 bits (range -16 to +15).
- R3: Opcode 0101 gives `result` = `src_a` AND the second operand. The second operand is `src_b` when bit 5 is clear and the sign-extended bits 4:0 when bit 5 is set.
- R4: Opcode 1001 with bits 5:0 all ones gives `result` = bitwise complement of `src_a`.
- R5: After each transfer of a well-formed operate instruction, exactly one bit of `cc_nzp` is set, in the order {N,Z,P} on bits 2:0. N is set when result bit 15 is 1, Z when the result is zero, and P otherwise. The new value is visible after the clock edge of the transfer.
- R6: Some words are not well-formed operate instructions: any other opcode, an add or AND with bit 5 clear and bits 4:3 non-zero, or a complement whose bits 5:0 are not all ones. For these, `wr_en` stays low and `cc_nzp` keeps its value.
- R7: `in_ready` equals `out_ready` and `out_valid` equals `in_valid`. A cycle without a transfer leaves `cc_nzp` unchanged.
- R8: Reset (active-low `rst_n`) sets `cc_nzp` to 3'b010 (Z). With `in_valid` low, `wr_en` is low.
- R9: `sr1_idx` shows instruction bits 8:6 and `sr2_idx` shows bits 2:0, for every instruction word.
- R10: An addition that overflows wraps and raises no extra indication. For example, 0x7FFF + 1 gives 0x8000 and sets N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit can accept (follows out_ready) |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Value of the first source register |
| src_b | input | 16 | Value of the second source register |
| sr1_idx | output | 3 | First source register index |
| sr2_idx | output | 3 | Second source register index |
| out_valid | output | 1 | Result is present (follows in_valid) |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 16 | Computed value |
| dst_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Result should be written (well-formed operate) |
| cc_nzp | output | 3 | Condition flags {N,Z,P} |

## Verification
The properties assume that `src_a` and `src_b` hold the values of the registers named by `sr1_idx` and `sr2_idx`. They also assume that `instr` and both operands stay stable while `in_valid` is high and `out_ready` is low. The stimulus presents a new word only at a falling edge and keeps it for the full cycle. During stalled cycles it holds the word unchanged. The operand values are supplied directly, so the rule that ties operands to indices is met by construction.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_ADD  = 2'd1,
    OPK_AND  = 2'd2,
    OPK_NOT  = 2'd3
  } op_kind_t;

  localparam int unsigned FLAG_W = 3;
  localparam logic [FLAG_W-1:0] CC_NEG  = 3'b100;
  localparam logic [FLAG_W-1:0] CC_ZERO = 3'b010;
  localparam logic [FLAG_W-1:0] CC_POS  = 3'b001;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 5,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [15:0]       instr,
  output op_kind_t          kind,
  output logic              use_imm,
  output logic [DATA_W-1:0] imm_ext,
  output logic [IDX_W-1:0]  dst,
  output logic [IDX_W-1:0]  sr1,
  output logic [IDX_W-1:0]  sr2
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  logic [3:0] opc;
  logic       reg_form_ok;
  logic       cpl_form_ok;

  assign opc         = instr[15:12];
  assign use_imm     = instr[5];
  assign reg_form_ok = instr[5] | (instr[4:3] == 2'b00);
  assign cpl_form_ok = (instr[5:0] == 6'b111111);
  assign imm_ext     = {{PAD_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign dst         = instr[11:9];
  assign sr1         = instr[8:6];
  assign sr2         = instr[2:0];

  always_comb begin
    kind = OPK_NONE;
    unique case (opc)
      OPC_ADD: if (reg_form_ok) kind = OPK_ADD;
      OPC_AND: if (reg_form_ok) kind = OPK_AND;
      OPC_NOT: if (cpl_form_ok) kind = OPK_NOT;
      default: kind = OPK_NONE;
    endcase
  end
endmodule

// File: rtl/opu_datapath.sv
module opu_datapath
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  op_kind_t          kind,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] opnd2;

  assign opnd2 = use_imm ? imm : b;

  always_comb begin
    unique case (kind)
      OPK_ADD: y = a + opnd2;
      OPK_AND: y = a & opnd2;
      OPK_NOT: y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/opu_flags.sv
module opu_flags
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] y,
  output logic [FLAG_W-1:0] nzp
);
  logic [FLAG_W-1:0] nzp_next;

  always_comb begin
    if (y[DATA_W-1])     nzp_next = CC_NEG;
    else if (y == '0)    nzp_next = CC_ZERO;
    else                 nzp_next = CC_POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   nzp <= CC_ZERO;
    else if (upd) nzp <= nzp_next;
  end
endmodule

// File: rtl/opu_core.sv
module opu_core
  import opu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IMM_W  = 5,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [IDX_W-1:0]  sr1_idx,
  output logic [IDX_W-1:0]  sr2_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dst_idx,
  output logic              wr_en,
  output logic [2:0]        cc_nzp
);
  op_kind_t          kind;
  logic              use_imm;
  logic [DATA_W-1:0] imm_ext;
  logic              xfer;

  opu_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .instr   (instr),
    .kind    (kind),
    .use_imm (use_imm),
    .imm_ext (imm_ext),
    .dst     (dst_idx),
    .sr1     (sr1_idx),
    .sr2     (sr2_idx)
  );

  opu_datapath #(.DATA_W(DATA_W)) u_dp (
    .kind    (kind),
    .use_imm (use_imm),
    .a       (src_a),
    .b       (src_b),
    .imm     (imm_ext),
    .y       (result)
  );

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign wr_en     = in_valid && (kind != OPK_NONE);
  assign xfer      = wr_en && out_ready;

  opu_flags #(.DATA_W(DATA_W)) u_cc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (xfer),
    .y     (result),
    .nzp   (cc_nzp)
  );
endmodule

// File: rtl/opu_core_chk.sv
module opu_core_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_ready,
  input logic [15:0]       instr,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [2:0]        cc_nzp
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_nzp) == 1);

  p_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && out_ready && result[DATA_W-1]) |=> (cc_nzp == 3'b100));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && out_ready && result == '0) |=> (cc_nzp == 3'b010));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && out_ready) |=> $stable(cc_nzp));

  p_we_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_valid);

  p_cpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && instr[15:12] == 4'b1001) |-> (result == ~src_a));

  p_addimm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && instr[15:12] == 4'b0001 && instr[5]) |->
      (result == src_a + {{(DATA_W-5){instr[4]}}, instr[4:0]}));

  p_malformed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[5] && instr[4:3] != 2'b00) |-> !wr_en);
endmodule

bind opu_core opu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_ready (out_ready),
  .instr     (instr),
  .src_a     (src_a),
  .result    (result),
  .wr_en     (wr_en),
  .cc_nzp    (cc_nzp)
);

// File: tb/opu_core_bench.sv
module opu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr = '0;
  logic [15:0] src_a = '0;
  logic [15:0] src_b = '0;
  logic [2:0]  sr1_idx, sr2_idx, dst_idx;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result;
  logic        wr_en;
  logic [2:0]  cc_nzp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [15:0] res;
    logic        we;
    logic [2:0]  dst;
    logic [2:0]  s1;
    logic [2:0]  s2;
    logic        rdy;
    logic [2:0]  cc;
  } item_t;

  item_t exp_q[$];
  logic [2:0] model_cc = 3'b010;

  always #5 clk = ~clk;

  opu_core u_opu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .src_a(src_a), .src_b(src_b), .sr1_idx(sr1_idx),
    .sr2_idx(sr2_idx), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .dst_idx(dst_idx), .wr_en(wr_en), .cc_nzp(cc_nzp)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] sx5(logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction

  task automatic send(string tag, logic [15:0] w, logic [15:0] a,
                      logic [15:0] b, logic rdy);
    item_t it;
    logic [15:0] op2;
    logic ok;
    op2 = w[5] ? sx5(w[4:0]) : b;
    ok = 1'b0;
    it.res = 16'h0;
    case (w[15:12])
      4'b0001: begin ok = w[5] || w[4:3] == 2'b00; it.res = a + op2; end
      4'b0101: begin ok = w[5] || w[4:3] == 2'b00; it.res = a & op2; end
      4'b1001: begin ok = w[5:0] == 6'h3F; it.res = ~a; end
      default: ok = 1'b0;
    endcase
    if (ok && rdy)
      model_cc = it.res[15] ? 3'b100 : (it.res == 16'h0 ? 3'b010 : 3'b001);
    it.tag = tag; it.we = ok; it.dst = w[11:9];
    it.s1 = w[8:6]; it.s2 = w[2:0]; it.rdy = rdy; it.cc = model_cc;
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_a = a; src_b = b; out_ready = rdy;
    exp_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        check({it.tag, " wr_en"}, 32'(wr_en), 32'(it.we));
        if (it.we) check({it.tag, " result"}, 32'(result), 32'(it.res));
        check({it.tag, " dst_idx"}, 32'(dst_idx), 32'(it.dst));
        check({it.tag, " R9 sr1_idx"}, 32'(sr1_idx), 32'(it.s1));
        check({it.tag, " R9 sr2_idx"}, 32'(sr2_idx), 32'(it.s2));
        check({it.tag, " R7 in_ready"}, 32'(in_ready), 32'(it.rdy));
        check({it.tag, " R7 out_valid"}, 32'(out_valid), 32'd1);
        @(posedge clk);
        #2;
        check({it.tag, " cc_nzp"}, 32'(cc_nzp), 32'(it.cc));
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R8 reset cc_nzp", 32'(cc_nzp), 32'(3'b010));
    check("R8 idle wr_en", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 cc after release", 32'(cc_nzp), 32'(3'b010));

    send("R1 add reg pos", 16'b0001_011_001_0_00_010, 16'd3, 16'd4, 1'b1);
    send("R2 add imm -1", 16'b0001_010_010_1_11111, 16'd5, 16'h0, 1'b1);
    send("R2 add imm +15", 16'b0001_100_101_1_01111, 16'hFFF0, 16'h0, 1'b1);
    send("R2 add imm -16", 16'b0001_100_101_1_10000, 16'd16, 16'h0, 1'b1);
    send("R3 and reg", 16'b0101_001_010_0_00_111, 16'hF0F0, 16'h8FF0, 1'b1);
    send("R3 and imm zero", 16'b0101_011_011_1_00000, 16'hBEEF, 16'h0, 1'b1);
    send("R3 and imm sext", 16'b0101_110_000_1_10101, 16'h1234, 16'h0, 1'b1);
    send("R4 not", 16'b1001_111_100_111111, 16'h00FF, 16'h0, 1'b1);
    send("R4 not to zero", 16'b1001_000_001_111111, 16'hFFFF, 16'h0, 1'b1);
    send("R10 wrap 7FFF+1", 16'b0001_001_001_1_00001, 16'h7FFF, 16'h0, 1'b1);
    send("R10 wrap FFFF+1", 16'b0001_001_001_0_00_011, 16'hFFFF, 16'd1, 1'b1);
    send("R5 pos set", 16'b0001_001_001_0_00_011, 16'd1, 16'd1, 1'b1);
    send("R6 add bad 4:3", 16'b0001_001_001_0_10_011, 16'h8000, 16'd0, 1'b1);
    send("R6 and bad 4:3", 16'b0101_001_001_0_01_011, 16'h0, 16'h0, 1'b1);
    send("R6 not bad low", 16'b1001_001_001_111110, 16'h0001, 16'h0, 1'b1);
    send("R6 other opcode", 16'b0000_010_000000101, 16'hFFFF, 16'h0, 1'b1);
    send("R7 stall no flag", 16'b0001_001_001_1_00000, 16'h0, 16'h0, 1'b0);
    send("R7 stall held", 16'b0001_001_001_1_00000, 16'h0, 16'h0, 1'b0);
    send("R7 accept after", 16'b0001_001_001_1_00000, 16'h0, 16'h0, 1'b1);
    send("R5 neg add", 16'b0001_001_001_0_00_010, 16'h9000, 16'h1000, 1'b1);

    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    check("R8 idle wr_en end", 32'(wr_en), 32'd0);
    check("R7 idle out_valid", 32'(out_valid), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule